// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a 32-bit processor's instruction fetch stage and the memory system. It is a blocking, read-only, direct-mapped cache. The processor drives a fetch address and holds it until the block delivers an instruction. A hit is answered in the same cycle with no stall. On a miss the processor is stalled. The block then issues a single read burst that covers the whole line and writes every returned word into the line. After the last word is written it hands the requested word to the processor.

A parameterised address window marks a region as uncached. A fetch into that window is sent to memory as a one-word read and is never allocated in the cache. Only one memory transaction can be in flight at a time, so the memory side needs no transaction identifiers. If a response carries the error flag, the flag is passed to the processor together with the returned word. A line whose refill saw an error stays invalid.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, every line is invalid. `cpu_valid`, `cpu_stall` and `mem_cmd_valid` are low while no fetch is requested, and the first cacheable fetch to any address misses.
- R2: A cacheable fetch whose line is valid and whose tag (address bits above the line index) matches raises `cpu_valid` in the same cycle as `cpu_req`, with the stored word. No memory command is issued and there is no stall cycle.
- R3: A cacheable miss issues exactly one command. Its address is the fetch address with the low log2(WORDS)+2 bits cleared, and `mem_cmd_words` equals WORDS. The block raises `cpu_valid` in the cycle after the last response beat is accepted.
- R4: After a refill without error, every word of that line hits. Word offset = address bits [log2(WORDS)+1:2] and line index = the next log2(LINES) bits.
- R5: A fetch with `(addr & UNC_MASK) == UNC_BASE` issues a one-word command at the address with bits [1:0] cleared. It returns that word and allocates nothing, so repeating the fetch issues a new command.
- R6: At most one transaction is outstanding. `mem_cmd_valid` is never high while response beats are still owed, a command is held stable until `mem_cmd_ready`, and `mem_rsp_ready` is high only while beats are owed.
- R7: If any beat of a refill has `mem_rsp_err` set, the fetched word is delivered with `cpu_err` high and the line stays invalid, so the next fetch to that line misses. An uncached response error is also passed to `cpu_err`. `cpu_err` is only high together with `cpu_valid`.
- R8: Two addresses with the same line index and different tags evict each other.
- R9: `cpu_stall` equals `cpu_req` and not `cpu_valid`, and `cpu_valid` is high only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Fetch request, held until `cpu_valid` |
| cpu_addr | input | 32 | Fetch byte address, held with the request |
| cpu_stall | output | 1 | Processor must wait |
| cpu_valid | output | 1 | Instruction delivered this cycle |
| cpu_instr | output | 32 | Delivered instruction word |
| cpu_err | output | 1 | Delivered word came with a memory error |
| mem_cmd_valid | output | 1 | Read command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_addr | output | 32 | Word-aligned start address of the read |
| mem_cmd_words | output | log2(WORDS)+1 | Number of words in the burst |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_ready | output | 1 | Block accepts response beats |
| mem_rsp_data | input | 32 | Response data word |
| mem_rsp_err | input | 1 | Response error flag |

## Verification
A corrupted valid bit or tag shows up at the ports within the next fetch to that line. A wrongly set bit gives a zero-stall delivery with stale data that the scoreboard flags. A wrongly cleared bit gives an extra command that the per-fetch command count catches. Fill words written to the wrong slot or with a bad beat counter appear as wrong data when the same line is re-read as hits, or as a burst that delivers too early. An uncached fetch that allocated, or a refill with an error that left the line valid, is caught on the very next access, because that access reports no command where one was required.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2,
      ST_DONE = 2'd3
   } ifc_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
   parameter int LINES = 16,
   parameter int TAG_W = 24,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_valid
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   // valid bits are reset; tags need no reset because a clear valid bit masks them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= wr_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
   parameter int LINES = 16,
   parameter int WORDS = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WOFS_W = $clog2(WORDS),
   localparam int DEPTH  = LINES * WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WOFS_W-1:0] rd_ofs,
   output logic [31:0]       rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WOFS_W-1:0] wr_ofs,
   input  logic [31:0]       wr_data
);
   logic [31:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[{wr_idx, wr_ofs}] <= wr_data;
      end
   end

   assign rd_data = mem_q[{rd_idx, rd_ofs}];
endmodule

// File: rtl/ifc_refill_ctrl.sv
module ifc_refill_ctrl
   import ifc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int WORDS = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WOFS_W = $clog2(WORDS),
   localparam int TAG_W  = 30 - WOFS_W - IDX_W,
   localparam int LEN_W  = WOFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [29:0]       cpu_waddr,
   input  logic              hit,
   input  logic              uncached,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic [31:0]       mem_cmd_addr,
   output logic [LEN_W-1:0]  mem_cmd_words,
   input  logic              mem_rsp_valid,
   output logic              mem_rsp_ready,
   input  logic [31:0]       mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              tag_we,
   output logic [IDX_W-1:0]  tag_widx,
   output logic [TAG_W-1:0]  tag_wtag,
   output logic              tag_wvalid,
   output logic              dat_we,
   output logic [IDX_W-1:0]  dat_widx,
   output logic [WOFS_W-1:0] dat_wofs,
   output ifc_state_e        state,
   output logic [31:0]       held_word,
   output logic              held_err
);
   ifc_state_e        st_q;
   logic [29:0]       waddr_q;
   logic              unc_q;
   logic              err_q;
   logic [31:0]       word_q;
   logic [WOFS_W-1:0] beat_q;

   logic              start;
   logic              beat_ok;
   logic              last_beat;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   logic [WOFS_W-1:0] cur_ofs;

   assign cur_ofs = waddr_q[WOFS_W-1:0];
   assign cur_idx = waddr_q[WOFS_W +: IDX_W];
   assign cur_tag = waddr_q[29 -: TAG_W];

   assign start     = (st_q == ST_IDLE) && cpu_req && (uncached || !hit);
   assign beat_ok   = (st_q == ST_RSP) && mem_rsp_valid;
   assign last_beat = unc_q || (beat_q == WOFS_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         waddr_q <= '0;
         unc_q   <= 1'b0;
         err_q   <= 1'b0;
         word_q  <= '0;
         beat_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q    <= ST_REQ;
                  waddr_q <= cpu_waddr;
                  unc_q   <= uncached;
                  err_q   <= 1'b0;
                  beat_q  <= '0;
               end
            end
            ST_REQ: begin
               if (mem_cmd_ready) begin
                  st_q <= ST_RSP;
               end
            end
            ST_RSP: begin
               if (mem_rsp_valid) begin
                  err_q <= err_q | mem_rsp_err;
                  if (unc_q || beat_q == cur_ofs) begin
                     word_q <= mem_rsp_data;
                  end
                  if (last_beat) begin
                     st_q <= ST_DONE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // command side
   assign mem_cmd_valid = (st_q == ST_REQ);
   assign mem_cmd_addr  = unc_q ? {waddr_q, 2'b00}
                                : {waddr_q[29:WOFS_W], {(WOFS_W + 2){1'b0}}};
   assign mem_cmd_words = unc_q ? LEN_W'(1) : LEN_W'(WORDS);
   assign mem_rsp_ready = (st_q == ST_RSP);

   // line bookkeeping: invalidate on miss start, validate on an error-free last beat
   always_comb begin
      tag_we     = 1'b0;
      tag_widx   = cur_idx;
      tag_wtag   = cur_tag;
      tag_wvalid = 1'b0;
      if (start && !uncached) begin
         tag_we   = 1'b1;
         tag_widx = cpu_waddr[WOFS_W +: IDX_W];
         tag_wtag = cpu_waddr[29 -: TAG_W];
      end else if (beat_ok && !unc_q && last_beat) begin
         tag_we     = 1'b1;
         tag_wvalid = !(err_q || mem_rsp_err);
      end
   end

   assign dat_we    = beat_ok && !unc_q;
   assign dat_widx  = cur_idx;
   assign dat_wofs  = beat_q;
   assign state     = st_q;
   assign held_word = word_q;
   assign held_err  = err_q;
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
   import ifc_pkg::*;
#(
   parameter int          LINES      = 16,
   parameter int          WORDS      = 4,
   parameter bit          UNC_ENABLE = 1'b1,
   parameter logic [31:0] UNC_MASK   = 32'hF000_0000,
   parameter logic [31:0] UNC_BASE   = 32'hB000_0000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic [31:0]            cpu_addr,
   output logic                   cpu_stall,
   output logic                   cpu_valid,
   output logic [31:0]            cpu_instr,
   output logic                   cpu_err,
   output logic                   mem_cmd_valid,
   input  logic                   mem_cmd_ready,
   output logic [31:0]            mem_cmd_addr,
   output logic [$clog2(WORDS):0] mem_cmd_words,
   input  logic                   mem_rsp_valid,
   output logic                   mem_rsp_ready,
   input  logic [31:0]            mem_rsp_data,
   input  logic                   mem_rsp_err
);
   localparam int IDX_W  = $clog2(LINES);
   localparam int WOFS_W = $clog2(WORDS);
   localparam int TAG_W  = 30 - WOFS_W - IDX_W;

   // elaboration-time parameter checks
   if (LINES < 2 || LINES > 1024 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("ifetch_cache: LINES must be a power of two in 2..1024");
   end
   if (WORDS < 2 || WORDS > 32 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("ifetch_cache: WORDS must be a power of two in 2..32");
   end

   logic [29:0]       waddr;
   logic [IDX_W-1:0]  rd_idx;
   logic [WOFS_W-1:0] rd_ofs;
   logic [TAG_W-1:0]  rd_tag_req;
   logic [TAG_W-1:0]  rd_tag;
   logic              rd_valid;
   logic [31:0]       rd_data;
   logic              hit;
   logic              uncached;
   logic              unused_ofs;

   logic              tag_we;
   logic [IDX_W-1:0]  tag_widx;
   logic [TAG_W-1:0]  tag_wtag;
   logic              tag_wvalid;
   logic              dat_we;
   logic [IDX_W-1:0]  dat_widx;
   logic [WOFS_W-1:0] dat_wofs;
   ifc_state_e        state;
   logic [31:0]       held_word;
   logic              held_err;

   assign unused_ofs = ^cpu_addr[1:0];
   assign waddr      = cpu_addr[31:2];
   assign rd_ofs     = waddr[WOFS_W-1:0];
   assign rd_idx     = waddr[WOFS_W +: IDX_W];
   assign rd_tag_req = waddr[29 -: TAG_W];

   if (UNC_ENABLE) begin : g_unc_window
      assign uncached = ((cpu_addr & UNC_MASK) == UNC_BASE);
   end else begin : g_all_cached
      assign uncached = 1'b0;
   end

   assign hit = rd_valid && (rd_tag == rd_tag_req);

   ifc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_tag   (rd_tag),
      .rd_valid (rd_valid),
      .wr_en    (tag_we),
      .wr_idx   (tag_widx),
      .wr_tag   (tag_wtag),
      .wr_valid (tag_wvalid)
   );

   ifc_data_store #(.LINES(LINES), .WORDS(WORDS)) u_data (
      .clk     (clk),
      .rd_idx  (rd_idx),
      .rd_ofs  (rd_ofs),
      .rd_data (rd_data),
      .wr_en   (dat_we),
      .wr_idx  (dat_widx),
      .wr_ofs  (dat_wofs),
      .wr_data (mem_rsp_data)
   );

   ifc_refill_ctrl #(.LINES(LINES), .WORDS(WORDS)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_waddr     (waddr),
      .hit           (hit),
      .uncached      (uncached),
      .mem_cmd_valid (mem_cmd_valid),
      .mem_cmd_ready (mem_cmd_ready),
      .mem_cmd_addr  (mem_cmd_addr),
      .mem_cmd_words (mem_cmd_words),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_ready (mem_rsp_ready),
      .mem_rsp_data  (mem_rsp_data),
      .mem_rsp_err   (mem_rsp_err),
      .tag_we        (tag_we),
      .tag_widx      (tag_widx),
      .tag_wtag      (tag_wtag),
      .tag_wvalid    (tag_wvalid),
      .dat_we        (dat_we),
      .dat_widx      (dat_widx),
      .dat_wofs      (dat_wofs),
      .state         (state),
      .held_word     (held_word),
      .held_err      (held_err)
   );

   // delivery: same-cycle hit from idle, or the captured word one cycle after the last beat
   always_comb begin
      cpu_valid = 1'b0;
      cpu_instr = rd_data;
      cpu_err   = 1'b0;
      if (state == ST_DONE) begin
         cpu_valid = cpu_req;
         cpu_instr = held_word;
         cpu_err   = held_err && cpu_req;
      end else if (state == ST_IDLE) begin
         cpu_valid = cpu_req && hit && !uncached;
      end
   end

   assign cpu_stall = cpu_req && !cpu_valid;
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
   parameter int          WORDS    = 4,
   parameter logic [31:0] UNC_MASK = 32'hF000_0000,
   parameter logic [31:0] UNC_BASE = 32'hB000_0000,
   parameter bit          UNC_ENABLE = 1'b1,
   localparam int LEN_W = $clog2(WORDS) + 1,
   localparam int ALN_W = $clog2(WORDS) + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_stall,
   input logic             cpu_valid,
   input logic             cpu_err,
   input logic             mem_cmd_valid,
   input logic             mem_cmd_ready,
   input logic [31:0]      mem_cmd_addr,
   input logic [LEN_W-1:0] mem_cmd_words,
   input logic             mem_rsp_valid,
   input logic             mem_rsp_ready
);
   logic [LEN_W-1:0] owed_q;
   logic             cmd_unc;

   assign cmd_unc = UNC_ENABLE && ((mem_cmd_addr & UNC_MASK) == UNC_BASE);

   // beats still owed by memory, counted from the port handshakes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else if (mem_cmd_valid && mem_cmd_ready) begin
         owed_q <= mem_cmd_words;
      end else if (mem_rsp_valid && mem_rsp_ready && owed_q != '0) begin
         owed_q <= owed_q - 1'b1;
      end
   end

   assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_ready) |=>
         (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_words)));

   assert_single_txn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid |-> (owed_q == '0));

   assert_rsp_in_txn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_ready |-> (owed_q != '0));

   assert_burst_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !cmd_unc) |->
         (mem_cmd_words == LEN_W'(WORDS) && mem_cmd_addr[ALN_W-1:0] == '0));

   assert_uncached_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && cmd_unc) |->
         (mem_cmd_words == LEN_W'(1) && mem_cmd_addr[1:0] == 2'b00));

   assert_valid_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> (cpu_req && !cpu_stall));

   assert_stall_meaning_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_valid) |-> cpu_stall);

   assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> cpu_valid);

   assert_delivery_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && mem_rsp_ready && owed_q == LEN_W'(1) && cpu_req) |=> cpu_valid);
endmodule

bind ifetch_cache ifetch_cache_chk #(
   .WORDS      (WORDS),
   .UNC_MASK   (UNC_MASK),
   .UNC_BASE   (UNC_BASE),
   .UNC_ENABLE (UNC_ENABLE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req       (cpu_req),
   .cpu_stall     (cpu_stall),
   .cpu_valid     (cpu_valid),
   .cpu_err       (cpu_err),
   .mem_cmd_valid (mem_cmd_valid),
   .mem_cmd_ready (mem_cmd_ready),
   .mem_cmd_addr  (mem_cmd_addr),
   .mem_cmd_words (mem_cmd_words),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;
   localparam int LINES = 16;
   localparam int WORDS = 4;
   localparam int LEN_W = $clog2(WORDS) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cpu_req = 1'b0;
   logic [31:0]      cpu_addr = '0;
   logic             cpu_stall, cpu_valid, cpu_err;
   logic [31:0]      cpu_instr;
   logic             mem_cmd_valid, mem_rsp_ready;
   logic             mem_cmd_ready = 1'b0;
   logic [31:0]      mem_cmd_addr;
   logic [LEN_W-1:0] mem_cmd_words;
   logic             mem_rsp_valid = 1'b0;
   logic [31:0]      mem_rsp_data = '0;
   logic             mem_rsp_err = 1'b0;

   always #5 clk = ~clk;

   ifetch_cache #(.LINES(LINES), .WORDS(WORDS)) u_ifetch_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_stall(cpu_stall), .cpu_valid(cpu_valid), .cpu_instr(cpu_instr), .cpu_err(cpu_err),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
      .mem_cmd_addr(mem_cmd_addr), .mem_cmd_words(mem_cmd_words),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cmd_cnt = 0;
   int proto_bad = 0;
   logic [31:0]      last_addr = '0;
   logic [LEN_W-1:0] last_len = '0;
   logic [31:0]      err_addr = 32'hFFFF_FFFF;

   logic [31:0] q_data [$];
   logic        q_err  [$];
   string       q_req  [$];

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {~a[15:0], a[15:0]} ^ 32'h13572468;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model: one command at a time, variable accept delay, one beat per cycle
   initial begin
      int gap = 0;
      logic [31:0] la;
      logic [LEN_W-1:0] ll;
      forever begin
         @(posedge clk); #1;
         if (rst_n && mem_cmd_valid) begin
            la = mem_cmd_addr; ll = mem_cmd_words;
            repeat (gap) begin
               @(posedge clk); #1;
               if (!mem_cmd_valid || mem_cmd_addr != la || mem_cmd_words != ll) proto_bad++;
            end
            mem_cmd_ready = 1'b1;
            @(posedge clk); #1;
            mem_cmd_ready = 1'b0;
            cmd_cnt++; last_addr = la; last_len = ll;
            gap = (gap + 1) % 3;
            for (int b = 0; b < int'(ll); b++) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = memf(la + 32'(4 * b));
               mem_rsp_err   = ((la + 32'(4 * b)) == err_addr);
               if (!mem_rsp_ready || mem_cmd_valid) proto_bad++;
               @(posedge clk); #1;
            end
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cpu_valid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R9", "unexpected delivery", cpu_instr, 32'h0);
         end else begin
            logic [31:0] ed;
            logic ee;
            string r;
            ed = q_data.pop_front(); ee = q_err.pop_front(); r = q_req.pop_front();
            check(cpu_instr == ed, r, "instruction", cpu_instr, ed);
            check(cpu_err == ee, r, "error flag", {31'b0, cpu_err}, {31'b0, ee});
         end
      end
   end

   task automatic fetch(input logic [31:0] a, input logic exp_err,
                        input int exp_cmds, input string req);
      int c0;
      int stalls;
      c0 = cmd_cnt; stalls = 0;
      q_data.push_back(memf({a[31:2], 2'b00}));
      q_err.push_back(exp_err);
      q_req.push_back(req);
      cpu_addr = a; cpu_req = 1'b1;
      forever begin
         @(negedge clk);
         if (cpu_valid) break;
         if (!cpu_stall) check(1'b0, "R9", "stall low while waiting", 32'h0, 32'h1);
         stalls++;
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
      check(cmd_cnt - c0 == exp_cmds, req, "command count", 32'(cmd_cnt - c0), 32'(exp_cmds));
      if (exp_cmds == 0) check(stalls == 0, req, "stall cycles on hit", 32'(stalls), 32'h0);
      else check(stalls > 0, req, "stall on miss", 32'(stalls), 32'h1);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R6", "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      check(!cpu_valid && !cpu_stall && !mem_cmd_valid, "R1", "idle outputs after reset",
            {29'b0, cpu_valid, cpu_stall, mem_cmd_valid}, 32'h0);
      @(posedge clk); #1;

      // R1/R3: first fetch misses, burst of a whole line, word offset 2 delivered
      fetch(32'h0000_0108, 1'b0, 1, "R3");
      check(last_addr == 32'h0000_0100, "R3", "burst start address", last_addr, 32'h100);
      check(last_len == LEN_W'(WORDS), "R3", "burst length", 32'(last_len), 32'(WORDS));

      // R2/R4: the rest of the line hits with no traffic
      fetch(32'h0000_0100, 1'b0, 0, "R4");
      fetch(32'h0000_0104, 1'b0, 0, "R4");
      fetch(32'h0000_010E, 1'b0, 0, "R2");
      fetch(32'h0000_0108, 1'b0, 0, "R2");

      // second line, last word requested
      fetch(32'h0000_027C, 1'b0, 1, "R3");
      check(last_addr == 32'h0000_0270, "R3", "burst start address", last_addr, 32'h270);
      fetch(32'h0000_0270, 1'b0, 0, "R4");

      // R8: same index, other tag evicts and is evicted
      fetch(32'h0000_1104, 1'b0, 1, "R8");
      fetch(32'h0000_1100, 1'b0, 0, "R8");
      fetch(32'h0000_0108, 1'b0, 1, "R8");
      fetch(32'h0000_1104, 1'b0, 1, "R8");
      fetch(32'h0000_027C, 1'b0, 0, "R8");

      // R5: uncached single word, no allocation
      fetch(32'hB000_0016, 1'b0, 1, "R5");
      check(last_addr == 32'hB000_0014, "R5", "uncached address", last_addr, 32'hB000_0014);
      check(last_len == LEN_W'(1), "R5", "uncached length", 32'(last_len), 32'h1);
      fetch(32'hB000_0014, 1'b0, 1, "R5");

      // R7: error on a non-requested beat of a refill
      err_addr = 32'h0000_030C;
      fetch(32'h0000_0304, 1'b1, 1, "R7");
      err_addr = 32'hFFFF_FFFF;
      fetch(32'h0000_0304, 1'b0, 1, "R7");
      fetch(32'h0000_030C, 1'b0, 0, "R7");
      err_addr = 32'hB000_0020;
      fetch(32'hB000_0020, 1'b1, 1, "R7");
      err_addr = 32'hFFFF_FFFF;

      // R6: protocol observed by the memory model
      check(proto_bad == 0, "R6", "command/response overlap or unstable command",
            32'(proto_bad), 32'h0);
      repeat (3) @(negedge clk);
      check(q_data.size() == 0, "R9", "undelivered fetches", 32'(q_data.size()), 32'h0);
      check(!cpu_stall && !cpu_valid, "R9", "idle without request",
            {30'b0, cpu_stall, cpu_valid}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule